// File: doc/BRIEF.md
# Add/Subtract Unit with Condition Flags

A combinational arithmetic slice for a small ALU. It adds or subtracts two 8-bit operands, with or without an incoming carry or borrow, through one shared binary adder. Subtraction is formed as A plus the bitwise inverse of B plus a carry-in. A select stage in front of the adder picks B or its inverse and picks the adder carry-in from the operation code and the carry flag.

The adder is split into a low part and a top full adder. This exposes the carry into the sign bit as well as the carry out of it. Overflow is the XOR of those two carries, so one formula serves all four operations. The unit reports carry, signed overflow, negative and zero together with the result. The caller holds the flags; this unit holds no state.

Top module: `addsub_flags`

## Requirements
- R1: With op_i = 2'b00 (add), y_o equals (a_i + b_i) mod 256 and carry_i has no effect.
- R2: With op_i = 2'b01 (add with carry), y_o equals (a_i + b_i + carry_i) mod 256.
- R3: With op_i = 2'b10 (subtract), y_o equals (a_i - b_i) mod 256, computed as a_i + ~b_i + 1, and carry_i has no effect.
- R4: With op_i = 2'b11 (subtract with borrow), y_o equals (a_i + ~b_i + carry_i) mod 256. A carry_i of 1 means no borrow is pending.
- R5: c_o is bit 8 of the 9-bit sum of a_i, the adder's B input (b_i for add ops, ~b_i for subtract ops) and the carry-in. For subtraction, 1 means no borrow.
- R6: For add ops, v_o is 1 exactly when a_i[7] equals b_i[7] and y_o[7] differs from them, whatever the carry-in.
- R7: For subtract ops, v_o is 1 exactly when a_i[7] differs from b_i[7] and y_o[7] differs from a_i[7], whatever the borrow. For example, 0x40 - 0xC0 gives 0x80 and flags overflow.
- R8: n_o equals y_o[7].
- R9: z_o is 1 exactly when all 8 bits of y_o are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 8 | First operand |
| b_i | input | 8 | Second operand |
| carry_i | input | 1 | Incoming carry flag (1 = no borrow for subtraction) |
| op_i | input | 2 | Operation: 00 add, 01 add with carry, 10 subtract, 11 subtract with borrow |
| y_o | output | 8 | Result |
| c_o | output | 1 | Carry out of bit 7 |
| v_o | output | 1 | Signed overflow |
| n_o | output | 1 | Negative (result sign) |
| z_o | output | 1 | Zero result |

## Verification
The carry and overflow flags come from the same top full adder, so they can rise in the same cycle. Zero can rise together with both of them. Directed vectors provoke this: 0x80 + 0x80 gives a zero result with carry and overflow both set. 0x40 - 0xC0 overflows with no carry, and 0x00 - 0x00 with borrow gives 0xFF with carry clear. Each flag is compared on its own against a bench model built from 9-bit arithmetic and the sign rules on the raw operands. The directed vectors are mixed with seeded random operands over all four operation codes.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_ADC = 2'b01,
    OP_SUB = 2'b10,
    OP_SBC = 2'b11
  } op_e;
endpackage

// File: rtl/operand_sel.sv
module operand_sel
  import addsub_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] b_i,
  input  logic         carry_i,
  input  op_e          op_i,
  output logic [W-1:0] b_eff_o,
  output logic         cin_o
);
  logic sub;

  always_comb begin
    sub = (op_i == OP_SUB) || (op_i == OP_SBC);
    b_eff_o = sub ? ~b_i : b_i;
    unique case (op_i)
      OP_ADD:  cin_o = 1'b0;
      OP_ADC:  cin_o = carry_i;
      OP_SUB:  cin_o = 1'b1;
      OP_SBC:  cin_o = carry_i;
      default: cin_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/split_adder.sv
module split_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         c_msb_o,
  output logic         cout_o
);
  localparam int LW = W - 1;
  logic [W-1:0] low;

  // low part widened by one bit: its top bit is the carry into the sign bit
  always_comb begin
    low     = {1'b0, a_i[LW-1:0]} + {1'b0, b_i[LW-1:0]} + {{LW{1'b0}}, cin_i};
    c_msb_o = low[W-1];
    sum_o   = {a_i[W-1] ^ b_i[W-1] ^ c_msb_o, low[LW-1:0]};
    cout_o  = (a_i[W-1] & b_i[W-1]) | ((a_i[W-1] ^ b_i[W-1]) & c_msb_o);
  end

  always_comb begin
    p_sum_match_r5: assert ({cout_o, sum_o} ==
        ({1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i}))
      else $error("R5 split sum mismatch");
  end
endmodule

// File: rtl/flag_gen.sv
module flag_gen #(
  parameter int W = 8
) (
  input  logic [W-1:0] sum_i,
  input  logic         c_msb_i,
  input  logic         cout_i,
  output logic         v_o,
  output logic         n_o,
  output logic         z_o
);
  always_comb begin
    v_o = c_msb_i ^ cout_i;
    n_o = sum_i[W-1];
    z_o = ~|sum_i;
  end

  always_comb begin
    p_zero_not_neg_r9: assert (!(z_o && n_o))
      else $error("R9 zero and negative together");
  end
endmodule

// File: rtl/addsub_flags.sv
module addsub_flags
  import addsub_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         carry_i,
  input  logic [1:0]   op_i,
  output logic [W-1:0] y_o,
  output logic         c_o,
  output logic         v_o,
  output logic         n_o,
  output logic         z_o
);
  localparam int MSB = W - 1;

  op_e          op;
  logic [W-1:0] b_eff;
  logic         cin;
  logic         c_msb;

  assign op = op_e'(op_i);

  operand_sel #(.W(W)) u_sel (
    .b_i(b_i), .carry_i(carry_i), .op_i(op), .b_eff_o(b_eff), .cin_o(cin)
  );

  split_adder #(.W(W)) u_add (
    .a_i(a_i), .b_i(b_eff), .cin_i(cin),
    .sum_o(y_o), .c_msb_o(c_msb), .cout_o(c_o)
  );

  flag_gen #(.W(W)) u_flg (
    .sum_i(y_o), .c_msb_i(c_msb), .cout_i(c_o),
    .v_o(v_o), .n_o(n_o), .z_o(z_o)
  );

  // sign rules on the raw operands, independent of the carry-XOR form
  always_comb begin
    if (!op_i[1]) begin
      p_add_ovf_r6: assert (v_o == ((a_i[MSB] == b_i[MSB]) && (y_o[MSB] != a_i[MSB])))
        else $error("R6 add overflow rule");
    end else begin
      p_sub_ovf_r7: assert (v_o == ((a_i[MSB] != b_i[MSB]) && (y_o[MSB] != a_i[MSB])))
        else $error("R7 sub overflow rule");
    end
    p_neg_sign_r8: assert (n_o == y_o[MSB])
      else $error("R8 negative flag");
  end
endmodule

// File: tb/sim_addsub_flags.sv
`timescale 1ns/1ps
module sim_addsub_flags;
  logic       clk = 1'b0;
  logic [7:0] a, b, y;
  logic       cr;
  logic [1:0] op;
  logic       c, v, n, z;
  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  addsub_flags u0 (
    .a_i(a), .b_i(b), .carry_i(cr), .op_i(op),
    .y_o(y), .c_o(c), .v_o(v), .n_o(n), .z_o(z)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: run hung, act=%0d exp<=100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // reference: 9-bit arithmetic plus sign rules on the raw operands
  function automatic logic [11:0] model(input logic [7:0] x, input logic [7:0] w,
                                        input logic ci, input logic [1:0] o);
    logic [8:0] s;
    logic       cin, ov;
    logic [7:0] be;
    be  = o[1] ? ~w : w;
    cin = (o == 2'b00) ? 1'b0 : (o == 2'b10) ? 1'b1 : ci;
    s   = {1'b0, x} + {1'b0, be} + {8'd0, cin};
    if (!o[1]) ov = (x[7] == w[7]) && (s[7] != x[7]);
    else       ov = (x[7] != w[7]) && (s[7] != x[7]);
    return {s[8], ov, s[7], (s[7:0] == 8'd0), s[7:0]};
  endfunction

  task automatic chk1(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s a=%h b=%h cr=%b op=%b act=%h exp=%h", tag, a, b, cr, op, act, exp);
    end
  endtask

  task automatic apply(input logic [7:0] x, input logic [7:0] w, input logic ci,
                       input logic [1:0] o);
    logic [11:0] e;
    @(posedge clk);
    a = x; b = w; cr = ci; op = o;
    @(negedge clk);
    e = model(x, w, ci, o);
    case (o)
      2'b00: chk1("R1 y", y, e[7:0]);
      2'b01: chk1("R2 y", y, e[7:0]);
      2'b10: chk1("R3 y", y, e[7:0]);
      default: chk1("R4 y", y, e[7:0]);
    endcase
    chk1("R5 c", {7'd0, c}, {7'd0, e[11]});
    chk1(o[1] ? "R7 v" : "R6 v", {7'd0, v}, {7'd0, e[10]});
    chk1("R8 n", {7'd0, n}, {7'd0, e[9]});
    chk1("R9 z", {7'd0, z}, {7'd0, e[8]});
  endtask

  // carry_i must not change any output for add and subtract
  task automatic ignore_cr(input logic [7:0] x, input logic [7:0] w, input logic [1:0] o,
                           input string tag);
    logic [11:0] r0;
    @(posedge clk); a = x; b = w; op = o; cr = 1'b0;
    @(negedge clk); r0 = {c, v, n, z, y};
    @(posedge clk); cr = 1'b1;
    @(negedge clk);
    checks++;
    if ({c, v, n, z, y} !== r0) begin
      fails++;
      $display("FAIL %s carry_i leaked act=%h exp=%h", tag, {c, v, n, z, y}, r0);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    a = '0; b = '0; cr = 1'b0; op = 2'b00;
    @(negedge clk);
    chk1("R9 idle zero", {7'd0, z}, 8'd1);
    chk1("R1 idle y", y, 8'h00);
    // directed corners
    apply(8'h80, 8'h80, 1'b0, 2'b00); // R1 R5 R6 R9: zero, carry, overflow together
    apply(8'h7F, 8'h01, 1'b0, 2'b00); // R6 positive overflow
    apply(8'h7F, 8'h00, 1'b1, 2'b01); // R2 carry-in causes overflow
    apply(8'hFF, 8'h00, 1'b1, 2'b01); // R2 R5 wrap to zero
    apply(8'h40, 8'hC0, 1'b0, 2'b10); // R7 +128 not representable
    apply(8'h80, 8'h01, 1'b0, 2'b10); // R7 negative overflow
    apply(8'h00, 8'h00, 1'b0, 2'b11); // R4 borrow: 0xFF, c=0
    apply(8'h00, 8'h00, 1'b1, 2'b11); // R4 no borrow: zero, c=1
    apply(8'h05, 8'h05, 1'b0, 2'b10); // R3 zero result
    apply(8'h80, 8'h7F, 1'b1, 2'b11); // R7 with no borrow
    ignore_cr(8'h3C, 8'h5A, 2'b00, "R1");
    ignore_cr(8'h3C, 8'h5A, 2'b10, "R3");
    for (int i = 0; i < 400; i++) begin
      apply(8'($urandom), 8'($urandom), 1'($urandom), 2'($urandom));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule